// File: doc/BRIEF.md
# Fixed-Priority Pending Interrupt Arbiter

This block keeps one pending flag per asynchronous interrupt source. Each cycle it picks at most one source to hand to the exception sequencer. The pick follows a fixed priority order, and the current machine-state enable bits filter which sources may win. Most sources raise their flag with a one-cycle pulse, and the flag clears when that source is taken. The external and critical-external sources are level-driven: their flag follows the input line, so taking them leaves them pending until the line drops.

The exception sequencer reads the winner as a 4-bit code together with a take strobe in the same cycle. It holds the busy input high while it cannot accept another interrupt. The code is the source index, and a lower index means a higher priority:

| Code | Source |
|---|---|
| 0 | reset |
| 1 | machine check |
| 2 | debug |
| 3 | hypervisor decrementer |
| 4 | critical external |
| 5 | watchdog |
| 6 | critical doorbell |
| 7 | fixed-interval timer |
| 8 | programmable-interval timer |
| 9 | decrementer |
| 10 | external |
| 11 | doorbell |
| 12 | performance monitor |
| 13 | thermal |

Top module: `irq_arbiter`

## Requirements
- R1: While rst_n is low, every pending flag is cleared and take is low.
- R2: A pending reset source (code 0) always wins when busy is low, whatever the enable bits are.
- R3: Machine check (code 1) is taken only while msr_me is high. While it is blocked it stays pending, and it is taken once msr_me rises.
- R4: Debug (code 2) is never gated. It ranks below machine check and above every other source.
- R5: The hypervisor decrementer (code 3) is taken only when hdec_en is high and at least one of the following holds: msr_ee high, msr_hv low, or msr_pr high.
- R6: Codes 4, 5 and 6 are taken only while msr_ce is high, and they rank in that order.
- R7: Codes 7 through 13 are taken only while msr_ee is high, and they rank in ascending code order.
- R8: At most one source is taken per cycle. A pulse source's flag clears at the clock edge that ends the cycle in which it was taken, so pending pulse sources drain one per cycle.
- R9: The level sources (codes 4 and 10) have a flag that equals their input as sampled at the previous edge. Taking such a source does not clear its flag.
- R10: While busy is high, take stays low and no flag is cleared.
- R11: When a pulse source is taken in the same cycle that its input pulses, the flag stays set.
- R12: A pulse sampled at a rising edge makes its source eligible from that edge on. take and take_code respond in the same cycle to the flags, the enable bits and busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_in | input | 14 | Source inputs, bit index = code; bits 4 and 10 are levels, the rest are pulses |
| msr_me | input | 1 | Machine-check enable |
| msr_ce | input | 1 | Critical-interrupt enable |
| msr_ee | input | 1 | External-interrupt enable |
| msr_hv | input | 1 | Hypervisor state |
| msr_pr | input | 1 | Problem (user) state |
| hdec_en | input | 1 | Hypervisor decrementer enable |
| busy | input | 1 | Sequencer cannot accept an interrupt |
| take | output | 1 | A source is taken this cycle |
| take_code | output | 4 | Code of the winning source |

## Verification
The bench builds the block with its default level mask, which marks codes 4 and 10 as level sources. That setting lets one run show both clearing behaviours side by side. The level-held external source stays taken on consecutive cycles, while a watchdog or timer pulse drains after one take. Because the gating groups are fixed, the vector table can walk each enable bit across its group boundary. For example, dropping msr_ce moves the winner from code 4 to code 7.

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 14,
  parameter logic [13:0] LEVEL_MASK = 14'h0410,
  localparam int CW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_in,
  input  logic            msr_me,
  input  logic            msr_ce,
  input  logic            msr_ee,
  input  logic            msr_hv,
  input  logic            msr_pr,
  input  logic            hdec_en,
  input  logic            busy,
  output logic            take,
  output logic [CW-1:0]   take_code
);

  logic [NSRC-1:0] pend_q, pend_d, elig, grant;
  logic hdec_ok;

  assign hdec_ok    = hdec_en & (msr_ee | ~msr_hv | msr_pr);
  assign elig[0]    = pend_q[0];
  assign elig[1]    = pend_q[1] & msr_me;
  assign elig[2]    = pend_q[2];
  assign elig[3]    = pend_q[3] & hdec_ok;
  assign elig[6:4]  = pend_q[6:4] & {3{msr_ce}};
  assign elig[13:7] = pend_q[13:7] & {7{msr_ee}};

  always_comb begin
    grant = '0;
    take_code = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant = '0;
        grant[i] = 1'b1;
        take_code = CW'(i);
      end
    end
  end

  assign take = (|elig) & ~busy;

  for (genvar i = 0; i < NSRC; i++) begin : g_pend
    if (LEVEL_MASK[i]) begin : g_lvl
      assign pend_d[i] = src_in[i];
    end else begin : g_pls
      assign pend_d[i] = src_in[i] | (pend_q[i] & ~(take & grant[i]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] src_in,
  input logic [13:0] pend_q,
  input logic        msr_me,
  input logic        msr_ee,
  input logic        msr_hv,
  input logic        msr_pr,
  input logic        hdec_en,
  input logic        busy,
  input logic        take,
  input logic [3:0]  take_code
);

  // R10
  busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take);

  // R2
  reset_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q[0] && !busy) |-> (take && take_code == 4'd0));

  // R3
  mcheck_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 4'd1) |-> msr_me);

  // R5
  hdec_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 4'd3) |-> (hdec_en && (msr_ee || !msr_hv || msr_pr)));

  // R7
  ee_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code >= 4'd7) |-> msr_ee);

  // R8
  pulse_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 4'd5 && !src_in[5]) |=> !pend_q[5]);

  // R9
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 4'd10 && src_in[10]) |=> pend_q[10]);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && take_code == 4'd5 && src_in[5]) |=> pend_q[5]);

endmodule

bind irq_arbiter irq_arbiter_chk u_chk (.*);

// File: tb/sim_irq_arbiter.sv
module sim_irq_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;
  // {mask[13:0], me, ce, ee, hv, pr, hd, take, code[3:0]}
  localparam logic [24:0] VEC [NV] = '{
    {14'h3FFF, 6'b111111, 1'b1, 4'd0},   // R2
    {14'h3FFE, 6'b011111, 1'b1, 4'd2},   // R3 R4
    {14'h0002, 6'b100000, 1'b1, 4'd1},   // R3
    {14'h0002, 6'b011111, 1'b0, 4'd0},   // R3
    {14'h0008, 6'b000101, 1'b0, 4'd0},   // R5
    {14'h0008, 6'b000001, 1'b1, 4'd3},   // R5
    {14'h0008, 6'b001000, 1'b0, 4'd0},   // R5
    {14'h0008, 6'b000111, 1'b1, 4'd3},   // R5
    {14'h3FF0, 6'b011000, 1'b1, 4'd4},   // R6
    {14'h3FF0, 6'b001000, 1'b1, 4'd7},   // R6 R7
    {14'h0060, 6'b010000, 1'b1, 4'd5},   // R6
    {14'h3F80, 6'b010000, 1'b0, 4'd0},   // R7
    {14'h3F00, 6'b001000, 1'b1, 4'd8},   // R7
    {14'h3C00, 6'b001000, 1'b1, 4'd10},  // R7
    {14'h2000, 6'b001000, 1'b1, 4'd13},  // R7
    {14'h3800, 6'b001000, 1'b1, 4'd11}   // R7 R12
  };

  logic clk = 0, rst_n = 0, busy = 0;
  logic [13:0] src_in = '0;
  logic me = 0, ce = 0, ee = 0, hv = 0, pr = 0, hd = 0;
  logic take;
  logic [3:0] code;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  irq_arbiter u0 (.clk(clk), .rst_n(rst_n), .src_in(src_in), .msr_me(me),
    .msr_ce(ce), .msr_ee(ee), .msr_hv(hv), .msr_pr(pr), .hdec_en(hd),
    .busy(busy), .take(take), .take_code(code));

  task automatic chk(string req, logic et, logic [3:0] ec);
    n_chk++;
    if (take !== et || (et && code !== ec)) begin
      n_fail++;
      $display("FAIL %s: take=%b code=%0d expected take=%b code=%0d", req, take, code, et, ec);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; src_in = '0;
    @(negedge clk); rst_n = 1;
  endtask

  task automatic set_msr(logic [5:0] m);
    {me, ce, ee, hv, pr, hd} = m;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: take=%b code=%0d expected completion", take, code);
    finish_run();
  end

  initial begin
    src_in = 14'h3FFF; set_msr(6'b111111);
    @(negedge clk); #1 chk("R1", 1'b0, 4'd0);
    src_in = '0;
    @(negedge clk); rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      do_reset();
      src_in = VEC[v][24:11]; set_msr(VEC[v][10:5]);
      @(negedge clk); src_in = '0;
      #1 chk($sformatf("vector %0d R2-group", v), VEC[v][4], VEC[v][3:0]);
    end

    // R3: blocked machine check stays pending, taken once enabled
    do_reset(); set_msr(6'b011111); src_in = 14'h0002;
    @(negedge clk); src_in = '0; #1 chk("R3 blocked", 1'b0, 4'd0);
    @(negedge clk); me = 1; #1 chk("R3 released", 1'b1, 4'd1);

    // R8: two pulses drain one per cycle
    do_reset(); set_msr(6'b001000); src_in = 14'h0180;
    @(negedge clk); src_in = '0; #1 chk("R8 first", 1'b1, 4'd7);
    @(negedge clk); #1 chk("R8 second", 1'b1, 4'd8);
    @(negedge clk); #1 chk("R8 drained", 1'b0, 4'd0);

    // R9: held external level stays taken, drops with its line
    do_reset(); set_msr(6'b001000); src_in = 14'h0400;
    @(negedge clk); #1 chk("R9 take1", 1'b1, 4'd10);
    @(negedge clk); #1 chk("R9 take2", 1'b1, 4'd10);
    @(negedge clk); #1 chk("R9 take3", 1'b1, 4'd10);
    src_in = '0;
    @(negedge clk); #1 chk("R9 dropped", 1'b0, 4'd0);

    // R10: busy holds off, flag kept
    do_reset(); set_msr(6'b010000); busy = 1; src_in = 14'h0020;
    @(negedge clk); src_in = '0; #1 chk("R10 busy1", 1'b0, 4'd0);
    @(negedge clk); #1 chk("R10 busy2", 1'b0, 4'd0);
    busy = 0; #1 chk("R10 release", 1'b1, 4'd5);

    // R11: set in the cycle of the take wins
    do_reset(); set_msr(6'b010000); src_in = 14'h0020;
    @(negedge clk); #1 chk("R11 first take", 1'b1, 4'd5);
    @(negedge clk); src_in = '0; #1 chk("R11 still pending", 1'b1, 4'd5);
    @(negedge clk); #1 chk("R8 cleared", 1'b0, 4'd0);

    finish_run();
  end
endmodule